// File: doc/BRIEF.md
# Privilege-Banked Accelerator Request Router

This block sits between a processor core and up to eight closely coupled accelerators. The core issues a request carrying a 3-bit target select, its current privilege level, an opcode field, and read/write enables and sizes. The router looks up the pair {privilege, select} in a bank table. The table is set by a parameter and returns either a port number or "no target". Valid is forwarded only to the chosen port. That port's ready and error are returned to the core in the same cycle. A request that has no target is answered by the router itself with ready and error both high, so the core takes an illegal-instruction trap.

A request is accepted when valid and ready are both high and error is low. The data phase follows one cycle after acceptance. A two-state machine records the accepted port and its enables at acceptance. It has two states: PH_IDLE, where no data phase is due, and PH_XFER, where a data phase is due. It has three transitions. ACCEPT goes from PH_IDLE to PH_XFER. CHAIN stays in PH_XFER when another request is accepted. DRAIN goes from PH_XFER to PH_IDLE when no request is accepted. During a data phase, read data is steered from the recorded port, not from whatever the live select shows. A per-port write strobe marks which accelerator must capture the write data, which is broadcast to all ports.

Top module: `acb_router`

## Requirements
- R1: `acc_vld` has at most one bit set, and it is all zero whenever `core_vld` is low.
- R2: The default bank table is as follows. At privilege 3, select s reaches port s. At privilege 1, selects 0 to 3 reach ports 4 to 7. At privilege 0, selects 0 and 1 reach ports 6 and 7. Every other {privilege, select} pair, including all of privilege 2, has no target. The table entry for a pair sits at index privilege*8+select, and an entry value of NPORT or more means no target.
- R3: For a mapped request, `core_rdy` and `core_err` equal `acc_rdy` and `acc_err` of the mapped port in the same cycle.
- R4: For a request with no target, `core_rdy`=1 and `core_err`=1 in the same cycle, and no `acc_vld` bit is set.
- R5: `acc_priv`, `acc_opc`, `acc_ren`, `acc_rsize`, `acc_wen`, `acc_wsize` and `acc_wdata` equal the matching core inputs in every cycle.
- R6: In the cycle after an accepted request with `core_wen`=1, `acc_wphase` has exactly the bit of the accepted port set. In every other cycle it is zero.
- R7: In the cycle after an accepted request with `core_ren`=1, `core_rdata` equals that port's `acc_rdata` slice (port p at bits p*64+63 down to p*64), even if the live select has changed. In every other cycle it is zero.
- R8: After reset, no data phase is pending, so `acc_wphase` and `core_rdata` are zero.
- R9: A request answered with ready and error (from a target or from the router) opens no data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| core_vld | input | 1 | Core request valid |
| core_priv | input | 2 | Privilege level (3 M, 1 S, 0 U) |
| core_sel | input | 3 | Accelerator select |
| core_opc | input | 20 | Opcode bits for accelerator decode |
| core_ren | input | 1 | Read requested |
| core_rsize | input | 1 | Read size (0 single, 1 double) |
| core_wen | input | 1 | Write requested |
| core_wsize | input | 1 | Write size (0 single, 1 double) |
| core_wdata | input | 64 | Write data, valid in the data phase |
| core_rdy | output | 1 | Request accepted by target or router |
| core_err | output | 1 | Request refused |
| core_rdata | output | 64 | Read data in the data phase |
| acc_vld | output | 8 | Per-port request valid |
| acc_priv | output | 2 | Broadcast privilege |
| acc_opc | output | 20 | Broadcast opcode |
| acc_ren | output | 1 | Broadcast read enable |
| acc_rsize | output | 1 | Broadcast read size |
| acc_wen | output | 1 | Broadcast write enable |
| acc_wsize | output | 1 | Broadcast write size |
| acc_wdata | output | 64 | Broadcast write data |
| acc_wphase | output | 8 | Per-port write data-phase strobe |
| acc_rdy | input | 8 | Per-port ready |
| acc_err | input | 8 | Per-port error |
| acc_rdata | input | 512 | Per-port read data, 64 bits each |

## Verification
A corrupted recorded port or enable shows up exactly one cycle after acceptance. It appears either as a strobe on the wrong `acc_wphase` bit or as read data taken from the wrong port's slice, and back-to-back requests with changing selects expose this at once. A stuck PH_XFER state leaks a strobe or nonzero read data into the following idle cycle. A wrong bank-table lookup appears in the request cycle itself, as a valid on the wrong port or a missing local error.

// File: rtl/acb_pkg.sv
package acb_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_XFER = 1'b1
    } phase_e;
endpackage

// File: rtl/acb_bank_decode.sv
module acb_bank_decode #(
    parameter int NPORT = 8,
    parameter int ENT_W = 4,
    parameter logic [32*ENT_W-1:0] MAP = '0,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [1:0]    priv,
    input  logic [2:0]    sel,
    output logic          hit,
    output logic [PW-1:0] port
);
    logic [ENT_W-1:0] entry;
    logic [4:0]       idx;

    always_comb begin
        idx   = {priv, sel};
        entry = MAP[idx*ENT_W +: ENT_W];
        hit   = (int'(entry) < NPORT);
        port  = entry[PW-1:0];
    end
endmodule

// File: rtl/acb_phase_fsm.sv
module acb_phase_fsm
    import acb_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          wen,
    input  logic          ren,
    input  logic [PW-1:0] port,
    output phase_e        st_q,
    output logic [PW-1:0] port_q,
    output logic          wen_q,
    output logic          ren_q
);
    phase_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_IDLE: if (accept) st_d = PH_XFER;       // ACCEPT
            PH_XFER: st_d = accept ? PH_XFER : PH_IDLE; // CHAIN / DRAIN
            default: st_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PH_IDLE;
            port_q <= '0;
            wen_q  <= 1'b0;
            ren_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                port_q <= port;
                wen_q  <= wen;
                ren_q  <= ren;
            end
        end
    end

    // R6: acceptance always opens a data phase on the next cycle
    p_accept_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> st_q == PH_XFER);
    // R9: no acceptance, no data phase
    p_noaccept_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> st_q == PH_IDLE);
endmodule

// File: rtl/acb_rdata_mux.sv
module acb_rdata_mux #(
    parameter int NPORT = 8,
    parameter int DW = 64,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                en,
    input  logic [PW-1:0]       port,
    input  logic [NPORT*DW-1:0] rdata_in,
    output logic [DW-1:0]       rdata_out
);
    logic [NPORT-1:0][DW-1:0] masked;

    for (genvar p = 0; p < NPORT; p++) begin : g_mask
        assign masked[p] = (en && int'(port) == p) ? rdata_in[p*DW +: DW] : '0;
    end

    always_comb begin
        rdata_out = '0;
        for (int p = 0; p < NPORT; p++) rdata_out = rdata_out | masked[p];
    end
endmodule

// File: rtl/acb_router.sv
module acb_router
    import acb_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int DW = 64,
    parameter int OPC_W = 20,
    parameter int ENT_W = 4,
    parameter logic [32*ENT_W-1:0] BANK_MAP = 128'h76543210_88888888_88887654_88888876
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_vld,
    input  logic [1:0]         core_priv,
    input  logic [2:0]         core_sel,
    input  logic [OPC_W-1:0]   core_opc,
    input  logic               core_ren,
    input  logic               core_rsize,
    input  logic               core_wen,
    input  logic               core_wsize,
    input  logic [DW-1:0]      core_wdata,
    output logic               core_rdy,
    output logic               core_err,
    output logic [DW-1:0]      core_rdata,
    output logic [NPORT-1:0]   acc_vld,
    output logic [1:0]         acc_priv,
    output logic [OPC_W-1:0]   acc_opc,
    output logic               acc_ren,
    output logic               acc_rsize,
    output logic               acc_wen,
    output logic               acc_wsize,
    output logic [DW-1:0]      acc_wdata,
    output logic [NPORT-1:0]   acc_wphase,
    input  logic [NPORT-1:0]   acc_rdy,
    input  logic [NPORT-1:0]   acc_err,
    input  logic [NPORT*DW-1:0] acc_rdata
);
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic          hit;
    logic [PW-1:0] port;
    logic          accept;
    phase_e        st_q;
    logic [PW-1:0] port_q;
    logic          wen_q;
    logic          ren_q;

    acb_bank_decode #(.NPORT(NPORT), .ENT_W(ENT_W), .MAP(BANK_MAP)) u_dec (
        .priv (core_priv),
        .sel  (core_sel),
        .hit  (hit),
        .port (port)
    );

    // request phase: return path from the mapped port or a local refusal
    always_comb begin
        if (hit) begin
            core_rdy = acc_rdy[port];
            core_err = acc_err[port];
        end else begin
            core_rdy = 1'b1;
            core_err = 1'b1;
        end
        accept = core_vld && hit && acc_rdy[port] && !acc_err[port];
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign acc_vld[p]    = core_vld && hit && (int'(port) == p);
        assign acc_wphase[p] = (st_q == PH_XFER) && wen_q && (int'(port_q) == p);
    end

    assign acc_priv  = core_priv;
    assign acc_opc   = core_opc;
    assign acc_ren   = core_ren;
    assign acc_rsize = core_rsize;
    assign acc_wen   = core_wen;
    assign acc_wsize = core_wsize;
    assign acc_wdata = core_wdata;

    acb_phase_fsm #(.PW(PW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .wen    (core_wen),
        .ren    (core_ren),
        .port   (port),
        .st_q   (st_q),
        .port_q (port_q),
        .wen_q  (wen_q),
        .ren_q  (ren_q)
    );

    acb_rdata_mux #(.NPORT(NPORT), .DW(DW)) u_rmux (
        .en        ((st_q == PH_XFER) && ren_q),
        .port      (port_q),
        .rdata_in  (acc_rdata),
        .rdata_out (core_rdata)
    );

    // R1
    p_vld_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_vld) && (core_vld || acc_vld == '0));
    // R4
    p_local_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld && acc_vld == '0) |-> (core_rdy && core_err));
    // R6
    p_wphase_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld && core_rdy && !core_err && core_wen) |=> $countones(acc_wphase) == 1);
    // R7
    p_rdata_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_vld && core_rdy && !core_err && core_ren) |=> core_rdata == '0);
    // R9
    p_err_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld && core_rdy && core_err) |=> acc_wphase == '0);
endmodule

// File: tb/acb_router_tb.sv
module acb_router_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         core_vld = 1'b0;
    logic [1:0]   core_priv = '0;
    logic [2:0]   core_sel = '0;
    logic [19:0]  core_opc = '0;
    logic         core_ren = 1'b0, core_rsize = 1'b0, core_wen = 1'b0, core_wsize = 1'b0;
    logic [63:0]  core_wdata = '0;
    logic         core_rdy, core_err;
    logic [63:0]  core_rdata;
    logic [7:0]   acc_vld;
    logic [1:0]   acc_priv;
    logic [19:0]  acc_opc;
    logic         acc_ren, acc_rsize, acc_wen, acc_wsize;
    logic [63:0]  acc_wdata;
    logic [7:0]   acc_wphase;
    logic [7:0]   acc_rdy = '0, acc_err = '0;
    logic [511:0] acc_rdata = '0;

    int n_chk = 0, n_fail = 0;
    logic       pend_acc = 1'b0, pend_ren = 1'b0, pend_wen = 1'b0;
    logic [2:0] pend_port = '0;

    always #5 clk = ~clk;

    acb_router u_dut (.*);

    function automatic int exp_port(input logic [1:0] pv, input logic [2:0] s);
        // R2: bench-side bank table, 8 means no target
        case (pv)
            2'd3: return int'(s);
            2'd1: return (s < 3'd4) ? int'(s) + 4 : 8;
            2'd0: return (s < 3'd2) ? int'(s) + 6 : 8;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] pv, input logic [2:0] s,
                        input logic rn, input logic wn, input logic [7:0] rdy, input logic [7:0] err);
        int ep;
        logic [7:0] exp_wph;
        logic [63:0] exp_rd;
        @(negedge clk);
        core_vld = v; core_priv = pv; core_sel = s; core_ren = rn; core_wen = wn;
        core_rsize = $urandom_range(0, 1); core_wsize = $urandom_range(0, 1);
        core_opc = 20'($urandom); core_wdata = {$urandom, $urandom};
        acc_rdy = rdy; acc_err = err;
        for (int p = 0; p < 8; p++) acc_rdata[p*64 +: 64] = {$urandom, $urandom};
        #1;
        exp_wph = (pend_acc && pend_wen) ? (8'd1 << pend_port) : 8'd0;
        exp_rd  = (pend_acc && pend_ren) ? acc_rdata[pend_port*64 +: 64] : 64'd0;
        chk("R6 wphase", 64'(acc_wphase), 64'(exp_wph));
        chk("R7 rdata", core_rdata, exp_rd);
        chk("R5 broadcast", {acc_priv, acc_opc, acc_ren, acc_rsize, acc_wen, acc_wsize},
            {core_priv, core_opc, core_ren, core_rsize, core_wen, core_wsize});
        chk("R5 wdata", acc_wdata, core_wdata);
        ep = exp_port(pv, s);
        if (!v) chk("R1 idle vld", 64'(acc_vld), 64'd0);
        else if (ep >= 8) begin
            chk("R4 no-target vld", 64'(acc_vld), 64'd0);
            chk("R4 no-target rdy/err", {62'd0, core_rdy, core_err}, 64'd3);
        end else begin
            chk("R1 R2 vld", 64'(acc_vld), 64'(8'd1 << ep));
            chk("R3 rdy/err", {62'd0, core_rdy, core_err}, {62'd0, rdy[ep], err[ep]});
        end
        pend_acc  = v && ep < 8 && rdy[ep[2:0]] && !err[ep[2:0]];
        pend_port = ep[2:0];
        pend_ren  = rn;
        pend_wen  = wn;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R8 reset wphase", 64'(acc_wphase), 64'd0);
        chk("R8 reset rdata", core_rdata, 64'd0);
        // directed corners
        step(1, 2'd0, 3'd0, 1, 1, 8'hFF, 8'h00);   // U sel0 -> port 6, read+write
        step(1, 2'd3, 3'd2, 1, 0, 8'hFF, 8'h00);   // R7 back-to-back, select changed
        step(1, 2'd2, 3'd5, 1, 1, 8'hFF, 8'h00);   // R4 privilege 2 unmapped
        step(0, 2'd3, 3'd0, 0, 0, 8'hFF, 8'h00);   // R9 no data phase after refusal
        step(1, 2'd1, 3'd3, 1, 1, 8'hFF, 8'h80);   // R9 target error on port 7
        step(1, 2'd1, 3'd0, 0, 1, 8'hEF, 8'h00);   // port 4 not ready
        step(1, 2'd0, 3'd7, 1, 1, 8'h00, 8'h00);   // R4 U sel7 unmapped
        step(1, 2'd3, 3'd7, 1, 1, 8'hFF, 8'h00);
        step(0, 2'd0, 3'd0, 0, 0, 8'h00, 8'h00);   // drain
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r, e;
            r = 8'($urandom) | 8'($urandom);
            e = 8'($urandom) & 8'($urandom) & 8'($urandom);
            step(($urandom % 4) != 0, 2'($urandom), 3'($urandom),
                 1'($urandom), 1'($urandom), r, e);
        end
        step(0, 2'd0, 3'd0, 0, 0, 8'h00, 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule